// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Bridge

This block sits between a big-endian host bus and the register port of an ATA disk interface. The host sees a 4096-byte window with one register every 16 bytes. Byte accesses reach the seven task-file registers and the device-control / alternate-status register. Halfword and word accesses reach only the data port, and the bridge swaps their byte lanes so that the little-endian data stream appears in host order.

Each host request lasts one cycle. In that same cycle the bridge raises a one-cycle read or write strobe and a register select toward the device. Read data is registered. It comes back with a one-cycle valid pulse in the cycle after the request. When a read falls on an address that maps to no register, the bridge returns all ones of the access width and the device sees no strobe. A write to such an address is dropped in the same way.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits [3:0] and every bit above bit 11 have no effect on decode.
- R2: A byte access at index 1..7 raises exactly one of dev_rd or dev_wr for that single cycle, with dev_sel equal to the index. Write data reaches the device as {24'h0, host_wdata[7:0]}, and read data returns as {24'h0, dev_rdata[7:0]}.
- R3: A byte access at index 8 or at index 22 selects dev_sel = 8. A write there goes to device control and a read returns alternate status.
- R4: A byte access at any other index raises no strobe. A read there returns 32'h0000_00FF.
- R5: Halfword (size 1) and word (size 2) accesses raise a strobe only at index 0, with dev_sel = 0. At any other index they raise no strobe, and a read returns 32'h0000_FFFF for a halfword or 32'hFFFF_FFFF for a word.
- R6: For a halfword data-port access the two low bytes are swapped in both directions, and the upper 16 bits are zero.
- R7: For a word data-port access all four bytes are reversed in both directions.
- R8: Every read request produces host_rvalid high for one cycle in the following cycle, with its data. Writes and idle cycles produce no host_rvalid.
- R9: Size code 3 is reserved. It raises no strobe, and a read with it returns 32'hFFFF_FFFF.
- R10: While rst_n is low (synchronous, active low) no strobe is raised, and host_rvalid is low in the cycle after a reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Host byte address |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_rvalid | output | 1 | Read data valid, one cycle after the request |
| host_rdata | output | 32 | Read data, right-aligned |
| dev_rd | output | 1 | Device register read strobe |
| dev_wr | output | 1 | Device register write strobe |
| dev_sel | output | 4 | Register select: 0 data, 1..7 task file, 8 control/alt status |
| dev_wdata | output | 32 | Lane-arranged write data to the device |
| dev_rdata | input | 32 | Device read data, valid in the strobe cycle |

## Verification
The assertions assume that the device answers a read strobe with dev_rdata in the same cycle, and that host_req is never held across the reset release with an expectation of a response. The bench drives each request for exactly one cycle at the falling edge and models the device as a combinational function of dev_sel. It holds a request active during reset only to confirm that the request is suppressed. All 256 indices are swept at every size in both directions, with varied upper and low address bits.

// File: rtl/ata_bridge_pkg.sv
// Shared types and constants for the memory-mapped ATA bridge.
// Assumes a 32-bit host data bus carrying right-aligned data.
package ata_bridge_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int SEL_W     = 4;
    localparam int SEL_DATA  = 0;
    localparam int SEL_CTRL  = 8;
    localparam int IDX_CTRL0 = 8;
    localparam int IDX_CTRL1 = 22;
endpackage

// File: rtl/ata_addr_decode.sv
// Turns a register index and an access size into a hit flag and a device select.
// Assumes the index is already stripped of the in-register offset bits.
module ata_addr_decode
    import ata_bridge_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  acc_size_e        size,
    output logic             hit,
    output logic [SEL_W-1:0] sel
);
    // Map index and size onto a device register, or flag a miss.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        unique case (size)
            SZ_BYTE: begin
                if (idx >= IDX_W'(1) && idx <= IDX_W'(7)) begin
                    hit = 1'b1;
                    sel = SEL_W'(idx);
                end else if (idx == IDX_W'(IDX_CTRL0) || idx == IDX_W'(IDX_CTRL1)) begin
                    hit = 1'b1;
                    sel = SEL_W'(SEL_CTRL);
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (idx == '0) begin
                    hit = 1'b1;
                    sel = SEL_W'(SEL_DATA);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ata_lane_swap.sv
// Rearranges byte lanes by access size: a byte passes through, a halfword swaps
// its two bytes and a word reverses all four. Unused upper lanes become zero.
// Assumes DATA_W is a multiple of 8 and at least 16.
module ata_lane_swap
    import ata_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / 8;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam int HK = (k < 2) ? (1 - k) : 0;
        localparam int WK = NB - 1 - k;
        logic [7:0] byte_l, half_l, word_l;
        assign byte_l = (k == 0) ? din[7:0] : 8'h00;
        assign half_l = (k < 2) ? din[8*HK +: 8] : 8'h00;
        assign word_l = din[8*WK +: 8];
        // Pick this lane's source by access size.
        always_comb begin
            unique case (size)
                SZ_BYTE: dout[8*k +: 8] = byte_l;
                SZ_HALF: dout[8*k +: 8] = half_l;
                SZ_WORD: dout[8*k +: 8] = word_l;
                default: dout[8*k +: 8] = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/ata_read_return.sv
// Registers read data and raises a one-cycle valid pulse after each read.
// A miss returns all ones of the access width. Assumes rd_go is already
// gated by reset.
module ata_read_return
    import ata_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              hit,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] swapped,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] miss_val;

    // Width-dependent all-ones value for unmapped reads.
    always_comb begin
        unique case (size)
            SZ_BYTE: miss_val = DATA_W'(8'hFF);
            SZ_HALF: miss_val = DATA_W'(16'hFFFF);
            default: miss_val = '1;
        endcase
    end

    // Capture the response of each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_go;
            if (rd_go) rdata <= hit ? swapped : miss_val;
        end
    end

    a_r8_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rvalid);
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !rvalid);
    a_r4_byte_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !hit && size == SZ_BYTE) |=> rdata == DATA_W'(8'hFF));
    a_r9_rsvd_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && size == SZ_RSVD) |=> rdata == '1);
endmodule

// File: rtl/mmio_ata_bridge.sv
// Top level: decodes a 4 KiB host window with 16-byte register stride onto an
// ATA register port and swaps data-port byte lanes for a big-endian host.
// Assumes one-cycle host requests and same-cycle device read data.
module mmio_ata_bridge
    import ata_bridge_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_W    = 12,
    parameter int STRIDE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [SEL_W-1:0]  dev_sel,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);
    localparam int IDX_W = WIN_W - STRIDE_W;

    acc_size_e         size;
    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] rd_swapped;
    logic              req_ok;
    logic              unused_addr_bits;

    assign size             = acc_size_e'(host_size);
    assign idx              = host_addr[WIN_W-1:STRIDE_W];
    assign unused_addr_bits = ^{host_addr[ADDR_W-1:WIN_W], host_addr[STRIDE_W-1:0]};
    assign req_ok           = host_req && rst_n;

    ata_addr_decode #(.IDX_W(IDX_W)) u_decode (
        .idx  (idx),
        .size (size),
        .hit  (hit),
        .sel  (sel)
    );

    ata_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .size (size),
        .din  (host_wdata),
        .dout (dev_wdata)
    );

    ata_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .size (size),
        .din  (dev_rdata),
        .dout (rd_swapped)
    );

    // Device strobes: one cycle per mapped host access, none in reset.
    always_comb begin
        dev_rd  = req_ok && !host_wr && hit;
        dev_wr  = req_ok &&  host_wr && hit;
        dev_sel = hit ? sel : '0;
    end

    ata_read_return #(.DATA_W(DATA_W)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (req_ok && !host_wr),
        .hit     (hit),
        .size    (size),
        .swapped (rd_swapped),
        .rvalid  (host_rvalid),
        .rdata   (host_rdata)
    );

    // R10: quiet device side while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r10_quiet_in_reset: assert (!dev_rd && !dev_wr);
        end
    end

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd && dev_wr));
    a_r2_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd || dev_wr) |-> host_req);
    a_r5_data_port_index0: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_rd || dev_wr) && dev_sel == SEL_W'(SEL_DATA)) |->
        (host_size != 2'd0 && host_addr[WIN_W-1:STRIDE_W] == '0));
    a_r9_rsvd_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_size == 2'd3) |-> !(dev_rd || dev_wr));
endmodule

// File: tb/test_mmio_ata_bridge.sv
// Exhaustive sweep of index, size and direction with arithmetic expectations.
module test_mmio_ata_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic [1:0]  host_size = '0;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        dev_rd, dev_wr;
    logic [3:0]  dev_sel;
    logic [31:0] dev_wdata, dev_rdata;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign dev_rdata = 32'h11223340 + {28'h0, dev_sel};

    mmio_ata_bridge i_mmio_ata_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_sel(dev_sel),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] arrange(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd0: return {24'h0, d[7:0]};
            2'd1: return {16'h0, d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    task automatic access(input bit wr, input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] wd);
        int  idx = int'(addr[11:4]);
        bit  hit;
        int  sel;
        logic [31:0] exp_r;
        hit = 0; sel = 0;
        if (sz == 2'd0) begin
            if (idx >= 1 && idx <= 7) begin hit = 1; sel = idx; end        // R2
            else if (idx == 8 || idx == 22) begin hit = 1; sel = 8; end    // R3
        end else if (sz != 2'd3 && idx == 0) begin hit = 1; sel = 0; end   // R5
        @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = addr; host_size = sz; host_wdata = wd;
        #1;
        chk(dev_rd == (!wr && hit), "R2 R4 R5 R9 dev_rd", {31'h0, dev_rd}, {31'h0, !wr && hit});
        chk(dev_wr == (wr && hit), "R2 R4 R5 R9 dev_wr", {31'h0, dev_wr}, {31'h0, wr && hit});
        if (hit) chk(dev_sel == sel[3:0], "R1 R3 dev_sel", {28'h0, dev_sel}, sel);
        if (hit && wr) chk(dev_wdata == arrange(sz, wd), "R6 R7 dev_wdata", dev_wdata, arrange(sz, wd));
        @(negedge clk);
        host_req = 0;
        chk(host_rvalid == !wr, "R8 rvalid", {31'h0, host_rvalid}, {31'h0, !wr});
        if (!wr) begin
            if (hit) exp_r = arrange(sz, 32'h11223340 + sel);
            else if (sz == 2'd0) exp_r = 32'h000000FF;                      // R4
            else if (sz == 2'd1) exp_r = 32'h0000FFFF;                      // R5
            else exp_r = 32'hFFFFFFFF;                                      // R5 R9
            chk(host_rdata == exp_r, "R4 R6 R7 R9 rdata", host_rdata, exp_r);
        end
    endtask

    initial begin
        // R10: request held during reset must stay silent.
        @(negedge clk);
        host_req = 1; host_wr = 0; host_addr = 32'h10; host_size = 0;
        #1 chk(!dev_rd && !dev_wr, "R10 strobes in reset", {30'h0, dev_rd, dev_wr}, 0);
        @(negedge clk);
        chk(!host_rvalid, "R10 rvalid after reset", {31'h0, host_rvalid}, 0);
        host_req = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!host_rvalid, "R10 idle rvalid", {31'h0, host_rvalid}, 0);
        for (int i = 0; i < 256; i++) begin
            for (int s = 0; s < 4; s++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] a;
                    a = {8'(i * 37 + s), 12'(i * 5), 8'(i), 4'(i + s + w)};    // R1 upper/low bits vary
                    access(w[0], a, s[1:0], 32'hA1B2C3D4 ^ {24'h0, 8'(i)});
                end
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule